// File: doc/BRIEF.md
# Memory-Mapped GPIO Set/Clear Port Bank

This block controls one or more 32-pin general-purpose I/O ports through a plain single-cycle register bus. Each port has four word registers. A direction register marks pins as driven outputs. An output latch can be changed in three ways: by a write-one-to-set register, by a write-one-to-clear register, or by a pin-value register that loads ones and zeros in one write. The pin inputs are sampled through a two-flop synchroniser and can be read back.

Every pin has a select input that hands it to an alternate peripheral. While a pin is handed over, its output enable is forced off and GPIO writes to its latch bit are dropped. A latch write also leaves alone any pin whose direction is input. Ports follow each other at a stride of 16 bytes. The port index is taken from the address bits above bit 3.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every port's direction register and output latch read as zero, and every `pin_oe` and `pin_out` bit is 0.
- R2: Offset 0x08 is the direction register. It is read/write on all bits, and bit n = 1 makes pin n an output. `pin_oe` bit n equals direction bit n AND NOT `pin_alt_sel` bit n.
- R3: Offset 0x04 is the set register. Writing 1 to bit n of it sets latch bit n, and writing 0 leaves the bit unchanged. Reading it returns the output latch, which also drives `pin_out`.
- R4: Offset 0x0C is the clear register. Writing 1 to bit n of it clears latch bit n, and writing 0 leaves the bit unchanged. Reading it returns zero.
- R5: When a bit is written through both the set and the clear register, the later write decides the latch value. Set then clear of bit 7 leaves it 0, and clear then set leaves it 1.
- R6: Offset 0x00 is the pin-value register. One write of value V gives the same latch as writing V to the set register and then NOT V to the clear register.
- R7: Set, clear and pin-value writes leave a latch bit unchanged when the pin's direction bit is 0 or its `pin_alt_sel` bit is 1.
- R8: Reading offset 0x00 returns `pin_in` through a two-flop synchroniser. A level applied before rising edge k is returned from edge k+1 onward.
- R9: Port p is decoded at byte base p*0x10, with the offset in address bits 3:2. A write to one port never changes another port.
- R10: An access is unmapped when its port index is NUM_PORTS or more, or when address bits 1:0 are non-zero. An unmapped write changes nothing, and an unmapped read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PORTS*PIN_W | Raw pin input levels, port p at bits p*PIN_W upward |
| pin_alt_sel | input | NUM_PORTS*PIN_W | 1 = pin owned by an alternate peripheral |
| pin_out | output | NUM_PORTS*PIN_W | Output latch values |
| pin_oe | output | NUM_PORTS*PIN_W | Output enables |

## Verification
The bench builds the block with NUM_PORTS = 2 and ADDR_W = 6. With these values, port indices 2 and 3 are valid addresses that decode to no port, so the unmapped-port case can be reached next to two real ports that must stay isolated from each other. At the full 32-pin width, walking-one sweeps cover every bit of the direction, set and clear registers. Pseudo-random patterns then mix direction, alternate-select and pin-value writes against a bench model of the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        REG_PINVAL = 2'd0,
        REG_SET    = 2'd1,
        REG_DIR    = 2'd2,
        REG_CLR    = 2'd3
    } gpio_reg_e;

    localparam int PORT_STRIDE_LOG2 = 4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
    import gpio_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             we_i,
    input  gpio_reg_e        reg_i,
    input  logic [PIN_W-1:0] wdata_i,
    input  logic [PIN_W-1:0] pin_sync_i,
    input  logic [PIN_W-1:0] alt_sel_i,
    output logic [PIN_W-1:0] out_o,
    output logic [PIN_W-1:0] oe_o,
    output logic [PIN_W-1:0] rdata_o
);
    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] latch;
    } port_t;

    port_t            st_d, st_q;
    logic [PIN_W-1:0] wmask;
    logic             wr_latch;

    assign wmask    = st_q.dir & ~alt_sel_i;
    assign wr_latch = hit_i && we_i && (reg_i != REG_DIR);

    always_comb begin
        st_d = st_q;
        if (hit_i && we_i) begin
            case (reg_i)
                REG_PINVAL: st_d.latch = (st_q.latch & ~wmask) | (wdata_i & wmask);
                REG_SET:    st_d.latch = st_q.latch | (wdata_i & wmask);
                REG_CLR:    st_d.latch = st_q.latch & ~(wdata_i & wmask);
                REG_DIR:    st_d.dir   = wdata_i;
                default:    st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (hit_i) begin
            case (reg_i)
                REG_PINVAL: rdata_o = pin_sync_i;
                REG_SET:    rdata_o = st_q.latch;
                REG_DIR:    rdata_o = st_q.dir;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign out_o = st_q.latch;
    assign oe_o  = wmask;

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && we_i && reg_i == REG_SET) |=>
        ((out_o & $past(wdata_i & st_q.dir & ~alt_sel_i)) == $past(wdata_i & st_q.dir & ~alt_sel_i))); // R3
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && we_i && reg_i == REG_CLR) |=>
        ((out_o & $past(wdata_i & st_q.dir & ~alt_sel_i)) == '0)); // R4
    AST_PINVAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && we_i && reg_i == REG_PINVAL) |=>
        ((out_o & $past(oe_o)) == ($past(wdata_i) & $past(oe_o)))); // R6
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> (((out_o ^ $past(out_o)) & ~$past(oe_o)) == '0)); // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_latch |=> $stable(out_o)); // R3
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PIN_W     = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [PIN_W-1:0]           bus_wdata,
    output logic [PIN_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PIN_W-1:0] pin_in,
    input  logic [NUM_PORTS*PIN_W-1:0] pin_alt_sel,
    output logic [NUM_PORTS*PIN_W-1:0] pin_out,
    output logic [NUM_PORTS*PIN_W-1:0] pin_oe
);
    localparam int IDX_W = ADDR_W - PORT_STRIDE_LOG2;

    logic [IDX_W-1:0]           port_idx;
    logic                       aligned;
    gpio_reg_e                  reg_sel;
    logic [NUM_PORTS-1:0]       hit;
    logic [NUM_PORTS*PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0]           port_rd [NUM_PORTS];

    assign port_idx = bus_addr[ADDR_W-1:PORT_STRIDE_LOG2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign reg_sel  = gpio_reg_e'(bus_addr[3:2]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign hit[p] = aligned && (port_idx == IDX_W'(p));

        gpio_in_sync #(.W(PIN_W)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(pin_in[p*PIN_W +: PIN_W]),
            .sync_o (pin_sync[p*PIN_W +: PIN_W])
        );

        gpio_port_core #(.PIN_W(PIN_W)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit[p]),
            .we_i      (bus_we),
            .reg_i     (reg_sel),
            .wdata_i   (bus_wdata),
            .pin_sync_i(pin_sync[p*PIN_W +: PIN_W]),
            .alt_sel_i (pin_alt_sel[p*PIN_W +: PIN_W]),
            .out_o     (pin_out[p*PIN_W +: PIN_W]),
            .oe_o      (pin_oe[p*PIN_W +: PIN_W]),
            .rdata_o   (port_rd[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rd[p];
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned || ({1'b0, port_idx} >= (IDX_W+1)'(NUM_PORTS))) |-> (bus_rdata == '0)); // R10
    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_alt_sel) == '0)); // R2
endmodule

// File: tb/tb_gpio_setclr_bank.sv
module tb_gpio_setclr_bank;
    localparam int NP = 2;
    localparam int PW = 32;
    localparam int AW = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [AW-1:0]     bus_addr;
    logic              bus_we;
    logic [PW-1:0]     bus_wdata;
    logic [PW-1:0]     bus_rdata;
    logic [NP*PW-1:0]  pin_in, pin_alt_sel, pin_out, pin_oe;

    logic [31:0] m_dir [NP];
    logic [31:0] m_out [NP];
    logic [31:0] alt   [NP];
    logic [31:0] pin   [NP];

    assign pin_in      = {pin[1], pin[0]};
    assign pin_alt_sel = {alt[1], alt[0]};

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    gpio_setclr_bank #(.NUM_PORTS(NP), .PIN_W(PW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_alt_sel(pin_alt_sel), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic wr_raw(input int a, input logic [31:0] d);
        int p, off;
        logic [31:0] wm;
        @(negedge clk);
        bus_addr  = a[AW-1:0];
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        p   = a / 16;
        off = a % 16;
        if (p < NP && (a % 4) == 0) begin
            wm = m_dir[p] & ~alt[p];
            case (off)
                0:  m_out[p] = (m_out[p] & ~wm) | (d & wm);
                4:  m_out[p] = m_out[p] | (d & wm);
                8:  m_dir[p] = d;
                12: m_out[p] = m_out[p] & ~(d & wm);
                default: ;
            endcase
        end
    endtask

    task automatic wr(input int p, input int off, input logic [31:0] d);
        wr_raw(p * 16 + off, d);
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = a[AW-1:0];
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_port(input int p, input string tag);
        logic [31:0] v;
        rd(p * 16 + 4, v);
        chk(v, m_out[p], {tag, " latch"});
        rd(p * 16 + 8, v);
        chk(v, m_dir[p], {tag, " dir"});
        chk(pin_out[p*32 +: 32], m_out[p], {tag, " pin_out"});
        chk(pin_oe[p*32 +: 32], m_dir[p] & ~alt[p], {tag, " pin_oe"});
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, x, prev0, prev1;
        int bad [9] = '{32, 36, 40, 44, 48, 56, 1, 6, 11};
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int p = 0; p < NP; p++) begin
            m_dir[p] = '0; m_out[p] = '0; alt[p] = '0; pin[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int p = 0; p < NP; p++) chk_port(p, "R1");

        // R2: walking one through direction register, alternate select masks oe
        for (int i = 0; i < 32; i++) begin
            wr(0, 8, 32'h1 << i);
            chk_port(0, "R2");
        end
        alt[0] = 32'h0000FFFF;
        wr(0, 8, 32'hFFFFFFFF);
        chk_port(0, "R2");
        alt[0] = '0;
        chk_port(0, "R2");

        // R3: set register sweep; writing 0 has no effect
        wr(1, 8, 32'hFFFFFFFF);
        for (int i = 0; i < 32; i++) begin
            wr(1, 4, 32'h1 << i);
            chk_port(1, "R3");
        end
        wr(1, 12, 32'h0);
        chk_port(1, "R4 zero write");
        // R4: clear register sweep, reads zero
        for (int i = 0; i < 32; i++) begin
            wr(1, 12, 32'h1 << i);
            chk_port(1, "R4");
        end
        wr(1, 4, 32'h0);
        chk_port(1, "R3 zero write");
        rd(16 + 12, v);
        chk(v, 32'h0, "R4 clear reads zero");

        // R5: later write wins
        wr(0, 8, 32'hFFFFFFFF);
        wr(0, 4, 32'h80);
        wr(0, 12, 32'h80);
        chk({31'h0, pin_out[7]}, 32'h0, "R5 set then clear");
        wr(0, 12, 32'h80);
        wr(0, 4, 32'h80);
        chk({31'h0, pin_out[7]}, 32'h1, "R5 clear then set");
        chk_port(0, "R5");

        // R6: pin-value write equals set then inverted clear
        wr(0, 0, 32'h0); wr(1, 8, 32'hFFFFFFFF); wr(1, 0, 32'h0);
        wr(0, 8, 32'h0000FF00); wr(1, 8, 32'h0000FF00);
        wr(0, 0, 32'h0000C700);
        wr(1, 4, 32'h0000C700);
        wr(1, 12, 32'h00003800);
        chk(pin_out[31:0], pin_out[63:32], "R6 pinval vs set/clear");
        chk_port(0, "R6");
        x = 32'h1234ABCD;
        for (int i = 0; i < 40; i++) begin
            x = lfsr(x);
            wr(0, 8, x ^ 32'h5A5A0FF0);
            x = lfsr(x);
            wr(0, 0, x);
            chk_port(0, "R6");
        end

        // R7: input pins and alternate pins keep their latch bits
        alt[0] = 32'h00FF00FF;
        wr(0, 8, 32'h0F0F0F0F);
        wr(0, 12, 32'hFFFFFFFF);
        wr(0, 4, 32'hFFFFFFFF);
        chk_port(0, "R7");
        wr(0, 0, 32'h0);
        chk_port(0, "R7");
        wr(0, 8, 32'hFFFFFFFF);
        chk_port(0, "R7");
        x = 32'hCAFE0001;
        for (int i = 0; i < 24; i++) begin
            x = lfsr(x);
            alt[0] = x;
            x = lfsr(x);
            wr(0, 8, x);
            x = lfsr(x);
            wr(0, (i % 3) * 4 + ((i % 3) == 2 ? 4 : 0), x);
            chk_port(0, "R7");
        end
        alt[0] = '0;

        // R8: two-flop synchronised input read
        prev0 = '0; prev1 = '0;
        x = 32'h0BADF00D;
        for (int i = 0; i < 20; i++) begin
            x = lfsr(x);
            @(negedge clk);
            pin[0] = x; pin[1] = ~x;
            @(posedge clk); @(negedge clk);
            rd(0, v);  chk(v, prev0, "R8 after one edge");
            @(posedge clk); @(negedge clk);
            rd(0, v);  chk(v, x, "R8 after two edges");
            rd(16, v); chk(v, ~x, "R8 port1");
            prev0 = x; prev1 = ~x;
        end

        // R9: port isolation at 0x10 stride
        wr(1, 8, 32'hFFFFFFFF);
        wr(1, 0, 32'hA5A5A5A5);
        chk_port(0, "R9 port0 untouched");
        chk_port(1, "R9 port1");
        wr(0, 8, 32'h3C3C3C3C);
        wr(0, 4, 32'hFFFFFFFF);
        chk_port(1, "R9 port1 untouched");
        chk_port(0, "R9 port0");

        // R10: unmapped writes ignored, reads zero
        for (int i = 0; i < 9; i++) begin
            wr_raw(bad[i], 32'h0);
            chk_port(0, "R10 port0");
            chk_port(1, "R10 port1");
            wr_raw(bad[i], 32'hFFFFFFFF);
            chk_port(0, "R10 port0");
            chk_port(1, "R10 port1");
            rd(bad[i], v);
            chk(v, 32'h0, "R10 unmapped read");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule